// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps three sticky status flags for an I2C controller and presents them, with five status bits supplied from elsewhere, as one 8-bit value for the CPU. The three flags are:

- master-active, in bit 7;
- arbitration-lost, in bit 6;
- extension-code-received, in bit 5.

The bus engine does not feed the block levels. It feeds it single-cycle event strobes:

- a start condition that this controller generated;
- a start condition seen on the bus;
- a stop condition seen on the bus;
- an arbitration loss;
- a release-from-communication request;
- a rising SCL edge.

Besides the strobes, the block takes:

- the controller enable;
- the byte being received;
- a CPU read strobe.

Each flag follows its own set and clear rules. The arbitration-lost flag clears itself once the CPU has read the register.

The extension-code decision is made by a small address tracker state machine with three states:

- TRK_IDLE: no transfer is in progress.
- TRK_ADDR: the address byte is being received.
- TRK_DATA: the address byte is over.

The transitions are:

- START_SEEN: any state goes to TRK_ADDR on a detected start, which also zeroes the SCL edge counter.
- BYTE_DONE: TRK_ADDR goes to TRK_DATA on the eighth SCL rising edge.
- BUS_END: any state goes to TRK_IDLE on a detected stop, a release request, or the enable falling.

On BYTE_DONE the upper nibble of the received byte is decoded. Either 0000 or 1111 sets the extension flag.

Every flag update is registered. The read value is combinational from the flag registers and the external low bits.

Top module: `i2c_stat_flags`

## Requirements
- R1: While reset is asserted all three flags are 0, so with the low bits at zero the register reads 00H.
- R2: Bits 4..0 of `stat_q` equal `low_stat` in the same cycle, with no register in the path. Bits 7, 6 and 5 carry the master, arbitration and extension flags.
- R3: A `evt_start_gen` pulse sets the master flag (bit 7) from the next cycle.
- R4: A `evt_stop_det`, `evt_arb_lost` or `evt_release` pulse clears the master flag from the next cycle, and wins over a simultaneous `evt_start_gen`.
- R5: An `evt_arb_lost` pulse sets the arbitration flag (bit 6) and clears the master flag in the same update.
- R6: A cycle with `rd_stb` high still shows the arbitration flag as it was. The flag reads 0 from the next cycle, unless `evt_arb_lost` is high in the read cycle, in which case the flag stays 1. Without a read the flag holds.
- R7: The extension flag (bit 5) is set at the eighth `evt_scl_rise` after a detected start, and only when `rx_addr[7:4]` is 4'b0000 or 4'b1111 at that edge. It is not set for other nibbles, it is not set earlier, and it is not set by later bytes.
- R8: A `evt_start_det`, `evt_stop_det` or `evt_release` pulse clears the extension flag, and wins over a simultaneous eighth edge. A detected start also restarts the edge count.
- R9: A 1-to-0 change of `ctl_en` clears all three flags and wins over any simultaneous set.
- R10: The tracker follows START_SEEN, BYTE_DONE and BUS_END as described. Its edge counter advances only in TRK_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en | input | 1 | Controller enable |
| evt_start_gen | input | 1 | Start condition generated by this controller |
| evt_start_det | input | 1 | Start condition detected on the bus |
| evt_stop_det | input | 1 | Stop condition detected on the bus |
| evt_arb_lost | input | 1 | Arbitration lost |
| evt_release | input | 1 | Release-from-communication request |
| evt_scl_rise | input | 1 | SCL rising edge |
| rx_addr | input | 8 | Byte being received |
| rd_stb | input | 1 | CPU read of the register |
| low_stat | input | 5 | External status bits 4..0 |
| stat_q | output | 8 | Register read value |

## Verification
Two functions can meet in one cycle on the arbitration flag: the read-triggered clear and a fresh arbitration loss. The vector table drives `rd_stb` and `evt_arb_lost` together and expects the flag to survive. A plain read is expected to clear it one cycle later.

On the extension flag, the eighth SCL edge can coincide with a detected start. The directed tests pulse both in the same cycle and expect the flag to stay 0 with the count restarted. A following full byte of 0000xxxx is then expected to set the flag on exactly its eighth edge.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_ADDR = 2'd1,
        TRK_DATA = 2'd2
    } trk_state_e;

    localparam int FLAG_N  = 3;
    localparam int FLG_EXT = 0;
    localparam int FLG_ARB = 1;
    localparam int FLG_MST = 2;

endpackage

// File: rtl/sf_flag_cell.sv
module sf_flag_cell #(
    parameter bit SET_WINS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    logic q_nx;

    generate
        if (SET_WINS) begin : g_set_prio
            always_comb begin
                if (kill)       q_nx = 1'b0;
                else if (set_i) q_nx = 1'b1;
                else if (clr_i) q_nx = 1'b0;
                else            q_nx = q;
            end
        end else begin : g_clr_prio
            always_comb begin
                if (kill || clr_i) q_nx = 1'b0;
                else if (set_i)    q_nx = 1'b1;
                else               q_nx = q;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nx;
    end

endmodule

// File: rtl/sf_addr_track.sv
module sf_addr_track
    import i2c_sf_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int ADDR_W    = 8,
    parameter int NIB_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              start_det,
    input  logic              bus_end,
    input  logic              scl_rise,
    input  logic [ADDR_W-1:0] rx_addr,
    output logic              ext_hit
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(BYTE_BITS - 1);
    localparam logic [NIB_W-1:0] NIB_LO = '0;
    localparam logic [NIB_W-1:0] NIB_HI = '1;

    trk_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             last_edge;
    logic [NIB_W-1:0] nib;

    assign nib       = rx_addr[ADDR_W-1 -: NIB_W];
    assign last_edge = scl_rise && (cnt_q == LAST_EDGE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TRK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Next state: BUS_END, START_SEEN, BYTE_DONE
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        if (kill || bus_end) begin
            st_nx  = TRK_IDLE;
            cnt_nx = '0;
        end else if (start_det) begin
            st_nx  = TRK_ADDR;
            cnt_nx = '0;
        end else begin
            unique case (st_q)
                TRK_IDLE: st_nx = TRK_IDLE;
                TRK_ADDR: begin
                    if (last_edge) begin
                        st_nx  = TRK_DATA;
                        cnt_nx = '0;
                    end else if (scl_rise) begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                TRK_DATA: st_nx = TRK_DATA;
                default:  st_nx = TRK_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ext_hit = 1'b0;
        unique case (st_q)
            TRK_ADDR: ext_hit = last_edge && !kill && !bus_end && !start_det &&
                                ((nib == NIB_LO) || (nib == NIB_HI));
            default:  ext_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_sf_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int ADDR_W    = 8,
    parameter int LOW_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              evt_start_gen,
    input  logic              evt_start_det,
    input  logic              evt_stop_det,
    input  logic              evt_arb_lost,
    input  logic              evt_release,
    input  logic              evt_scl_rise,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rd_stb,
    input  logic [LOW_W-1:0]  low_stat,
    output logic [LOW_W+FLAG_N-1:0] stat_q
);

    localparam logic [FLAG_N-1:0] SET_PRIO = FLAG_N'(1 << FLG_ARB);

    logic              en_d;
    logic              en_fall;
    logic              ext_hit;
    logic [FLAG_N-1:0] f_set, f_clr, f_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= ctl_en;
    end
    assign en_fall = en_d && !ctl_en;

    sf_addr_track #(
        .BYTE_BITS (BYTE_BITS),
        .ADDR_W    (ADDR_W)
    ) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (en_fall),
        .start_det (evt_start_det),
        .bus_end   (evt_stop_det || evt_release),
        .scl_rise  (evt_scl_rise),
        .rx_addr   (rx_addr),
        .ext_hit   (ext_hit)
    );

    always_comb begin
        f_set          = '0;
        f_clr          = '0;
        f_set[FLG_MST] = evt_start_gen;
        f_clr[FLG_MST] = evt_stop_det || evt_arb_lost || evt_release;
        f_set[FLG_ARB] = evt_arb_lost;
        f_clr[FLG_ARB] = rd_stb;
        f_set[FLG_EXT] = ext_hit;
        f_clr[FLG_EXT] = evt_start_det || evt_stop_det || evt_release;
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        sf_flag_cell #(.SET_WINS(SET_PRIO[g])) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (en_fall),
            .set_i (f_set[g]),
            .clr_i (f_clr[g]),
            .q     (f_q[g])
        );
    end

    assign stat_q = {f_q, low_stat};

endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_en,
    input logic       evt_start_gen,
    input logic       evt_start_det,
    input logic       evt_stop_det,
    input logic       evt_arb_lost,
    input logic       evt_release,
    input logic       evt_scl_rise,
    input logic       rd_stb,
    input logic [7:0] stat_q
);

    // R1
    rst_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (stat_q[7:5] == 3'b000));

    // R3
    mst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start_gen && ctl_en && !evt_stop_det && !evt_arb_lost && !evt_release)
        |=> stat_q[7]);

    // R4
    mst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop_det || evt_arb_lost || evt_release) |=> !stat_q[7]);

    // R5
    arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_arb_lost && ctl_en) |=> stat_q[6]);

    // R6
    arb_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !evt_arb_lost) |=> !stat_q[6]);

    // R6
    arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[6] && !rd_stb && ctl_en) |=> stat_q[6]);

    // R7
    ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[5]) |-> $past(evt_scl_rise));

    // R8
    ext_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start_det || evt_stop_det || evt_release) |=> !stat_q[5]);

    // R9
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && $past(ctl_en)) |=> (stat_q[7:5] == 3'b000));

endmodule

bind i2c_stat_flags i2c_stat_flags_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_en        (ctl_en),
    .evt_start_gen (evt_start_gen),
    .evt_start_det (evt_start_det),
    .evt_stop_det  (evt_stop_det),
    .evt_arb_lost  (evt_arb_lost),
    .evt_release   (evt_release),
    .evt_scl_rise  (evt_scl_rise),
    .rd_stb        (rd_stb),
    .stat_q        (stat_q)
);

// File: tb/i2c_stat_flags_tb_top.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_en = 1'b1;
    logic       sg = 1'b0, sd = 1'b0, sp = 1'b0, al = 1'b0, rl = 1'b0, sr = 1'b0, rd = 1'b0;
    logic [7:0] rx_addr = 8'h00;
    logic [4:0] low_stat = 5'h00;
    logic [7:0] stat_q;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    i2c_stat_flags dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_en        (ctl_en),
        .evt_start_gen (sg),
        .evt_start_det (sd),
        .evt_stop_det  (sp),
        .evt_arb_lost  (al),
        .evt_release   (rl),
        .evt_scl_rise  (sr),
        .rx_addr       (rx_addr),
        .rd_stb        (rd),
        .low_stat      (low_stat),
        .stat_q        (stat_q)
    );

    // vector: [22:19] req, [18] en, [17:11] sg sd sp al rl sr rd, [10:3] addr, [2:0] exp {mst,arb,ext}
    localparam int NV = 18;
    localparam logic [22:0] VEC [0:NV-1] = '{
        {4'd1, 1'b1, 7'b0000000, 8'h00, 3'b000},  // R1 idle after reset
        {4'd3, 1'b1, 7'b1000000, 8'h00, 3'b100},  // R3 start generated
        {4'd3, 1'b1, 7'b0000000, 8'h00, 3'b100},  // R3 holds
        {4'd4, 1'b1, 7'b0010000, 8'h00, 3'b000},  // R4 stop clears
        {4'd3, 1'b1, 7'b1000000, 8'h00, 3'b100},  // R3
        {4'd4, 1'b1, 7'b0000100, 8'h00, 3'b000},  // R4 release clears
        {4'd4, 1'b1, 7'b1010000, 8'h00, 3'b000},  // R4 clear beats set
        {4'd3, 1'b1, 7'b1000000, 8'h00, 3'b100},  // R3
        {4'd5, 1'b1, 7'b0001000, 8'h00, 3'b010},  // R5 loss sets arb, clears mst
        {4'd6, 1'b1, 7'b0000000, 8'h00, 3'b010},  // R6 holds without read
        {4'd6, 1'b1, 7'b0000001, 8'h00, 3'b000},  // R6 read clears
        {4'd5, 1'b1, 7'b0001000, 8'h00, 3'b010},  // R5
        {4'd6, 1'b1, 7'b0001001, 8'h00, 3'b010},  // R6 set beats read clear
        {4'd6, 1'b1, 7'b0000001, 8'h00, 3'b000},  // R6
        {4'd3, 1'b1, 7'b1000000, 8'h00, 3'b100},  // R3
        {4'd9, 1'b0, 7'b0000000, 8'h00, 3'b000},  // R9 enable fall clears
        {4'd9, 1'b1, 7'b0000000, 8'h00, 3'b000},  // R9 re-enable
        {4'd5, 1'b1, 7'b1001000, 8'h00, 3'b010}   // R5 loss beats start
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        sg = 0; sd = 0; sp = 0; al = 0; rl = 0; sr = 0; rd = 0;
    endtask

    // one cycle of events, then check flags after the edge
    task automatic step(input logic [6:0] ev, input logic [2:0] exp, input string tag);
        @(negedge clk);
        {sg, sd, sp, al, rl, sr, rd} = ev;
        @(posedge clk);
        #1;
        chk(tag, {5'd0, stat_q[7:5]}, {5'd0, exp});
        @(negedge clk);
        idle_all();
    endtask

    // start detect then eight SCL rises with byte b
    task automatic addr_byte(input logic [7:0] b, input logic exp_ext, input string tag);
        rx_addr = b;
        step(7'b0100000, 3'b000, "R8 start clears ext");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sr = 1'b1;
            @(posedge clk);
            #1;
            if (k == 6) chk("R7 no set before eighth edge", {7'd0, stat_q[5]}, 8'd0);
            if (k == 7) chk(tag, {7'd0, stat_q[5]}, {7'd0, exp_ext});
        end
        @(negedge clk);
        sr = 1'b0;
    endtask

    task automatic data_byte(input logic [7:0] b, input logic exp_ext);
        rx_addr = b;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sr = 1'b1;
            @(posedge clk);
        end
        #1;
        chk("R7 data byte ignored", {7'd0, stat_q[5]}, {7'd0, exp_ext});
        @(negedge clk);
        sr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset value", stat_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctl_en = VEC[i][18];
            {sg, sd, sp, al, rl, sr, rd} = VEC[i][17:11];
            rx_addr = VEC[i][10:3];
            @(posedge clk);
            #1;
            n_chk++;
            if (stat_q[7:5] !== VEC[i][2:0]) begin
                n_bad++;
                $display("FAIL R%0d vector %0d actual=%03b expected=%03b",
                         VEC[i][22:19], i, stat_q[7:5], VEC[i][2:0]);
            end
        end
        @(negedge clk);
        idle_all();
        ctl_en = 1'b1;

        // R2: low bits pass straight through
        low_stat = 5'h15;
        #1;
        chk("R2 low bits", {3'd0, stat_q[4:0]}, 8'h15);
        low_stat = 5'h0A;
        #1;
        chk("R2 low bits", {3'd0, stat_q[4:0]}, 8'h0A);
        low_stat = 5'h00;

        // R6: read cycle shows pre-clear value (flags: arb=1, mst=0 after last vector)
        @(negedge clk);
        rd = 1'b1;
        #1;
        chk("R6 read returns old value", {7'd0, stat_q[6]}, 8'd1);
        @(posedge clk);
        #1;
        chk("R6 cleared after read", {7'd0, stat_q[6]}, 8'd0);
        @(negedge clk);
        rd = 1'b0;

        // R7 / R10: extension code decode
        addr_byte(8'h0A, 1'b1, "R7 nibble 0000");
        data_byte(8'h3C, 1'b1);
        step(7'b0010000, 3'b000, "R8 stop clears ext");
        addr_byte(8'hF3, 1'b1, "R7 nibble 1111");
        addr_byte(8'h5C, 1'b0, "R7 nibble 0101");
        data_byte(8'h00, 1'b0);
        step(7'b0000000, 3'b000, "R10 idle data phase");

        // R8: start in mid-byte restarts the count
        rx_addr = 8'h07;
        step(7'b0100000, 3'b000, "R8 start");
        for (int k = 0; k < 4; k++) step(7'b0000010, 3'b000, "R10 counting");
        step(7'b0100000, 3'b000, "R8 restart");
        for (int k = 0; k < 7; k++) step(7'b0000010, 3'b000, "R8 count restarted");
        step(7'b0000010, 3'b001, "R8 eighth edge after restart");
        step(7'b0000100, 3'b000, "R8 release clears ext");

        // R8: start together with the eighth edge wins
        step(7'b0100000, 3'b000, "R8 start");
        for (int k = 0; k < 7; k++) step(7'b0000010, 3'b000, "R10 counting");
        step(7'b0100010, 3'b000, "R8 start beats eighth edge");
        for (int k = 0; k < 7; k++) step(7'b0000010, 3'b000, "R7 recount");
        step(7'b0000010, 3'b001, "R7 set on new eighth edge");

        // R9: enable fall clears everything, even with a set pending
        step(7'b1000000, 3'b101, "R3 with ext held");
        @(negedge clk);
        ctl_en = 1'b0;
        al = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 enable fall beats set", {5'd0, stat_q[7:5]}, 8'd0);
        @(negedge clk);
        idle_all();
        ctl_en = 1'b1;

        // R1: reset mid-run
        step(7'b1000000, 3'b100, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", stat_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule